// File: doc/BRIEF.md
# Index/Data Configuration Register Port

This block is a legacy, I/O-mapped configuration space of 256 byte registers that a host reaches through two adjacent byte ports. The host first writes a register number to the index port and then reads or writes that register through the data port. Only a handful of indices in the top window hold writable state. Every other index is write-protected and reads as zero. Six of the writable registers come out of reset with fixed values. Two of them describe where the two serial ports sit, and writing them with anything but their home values sets a sticky flag so that the rest of the chip can see that an unsupported move was requested.

The pair answers only while an external decode-enable bit is high. That bit is bit 1 of the bridge configuration byte, which another block holds. While the bit is low, neither address is claimed, reads return 0xFF and writes are dropped. Results are registered: a request presented in one cycle shows its read data and claim strobe in the next cycle.

Top module: `idx_cfg_port`

## Requirements
- R1: A write to the index port (I/O address 0x3F0) while decoded loads the index with `io_wdata`. The index resets to 0x00. An index write changes no register's contents.
- R2: A read of either port while decoded returns, one cycle later, the register selected by the current index on `io_rdata`, with `io_ack` high in that same cycle.
- R3: A data-port (0x3F1) write while decoded stores `io_wdata` into the selected register when the index is one of 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC. A later read returns the stored value.
- R4: Data-port writes to every other index (0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB, 0xFD–0xFF) are ignored, and those registers always read 0x00.
- R5: After reset, 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE, and every other register reads 0x00.
- R6: `reloc_flag[0]` sets when 0xE7 is written with a value other than 0xFE. `reloc_flag[1]` sets when 0xE8 is written with a value other than 0xBE. Both bits stay set until reset, and the written value is still stored.
- R7: While `io_dec_en` is low, and for any address other than 0x3F0/0x3F1, the next cycle shows `io_ack` low and `io_rdata` 0xFF, and writes change neither the index nor any register.
- R8: A read and a data write in the same cycle return the register's old value, and the new value is visible from the next access on.
- R9: A decoded write of either port raises `io_ack` in the following cycle. A cycle with no decoded read shows `io_rdata` 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 8 | Write byte |
| io_dec_en | input | 1 | Decode enable, bit 1 of the bridge configuration byte |
| io_rdata | output | 8 | Registered read byte, 0xFF when nothing is read |
| io_ack | output | 1 | Registered claim of the previous cycle's access |
| reloc_flag | output | 2 | Sticky unsupported-relocation flags for the two serial ports |

## Verification
Every result is due exactly one clock edge after its request: read data and claim strobe appear after the edge that samples the strobe, and index and register updates take effect at that same edge, so a read in the following cycle sees them. The bench drives each access on the falling edge, lets one rising edge pass, and samples the outputs 1 ns later, before it clears the strobes. The relocation flags and the read data of a combined read-and-write are checked against that same single-edge latency.

// File: rtl/idx_cfg_pkg.sv
package idx_cfg_pkg;

  localparam int unsigned BYTE_W = 8;

  // serial-port base registers and their home values
  localparam logic [7:0] SER_A_IDX  = 8'hE7;
  localparam logic [7:0] SER_A_HOME = 8'hFE;
  localparam logic [7:0] SER_B_IDX  = 8'hE8;
  localparam logic [7:0] SER_B_HOME = 8'hBE;

  // indices that hold writable state; everything else is protected
  function automatic logic idx_writable(input logic [7:0] idx);
    logic ok;
    case (idx)
      8'hE0, 8'hE1, 8'hE2, 8'hE3,
      8'hE6, 8'hE7, 8'hE8,
      8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2,
      8'hF4, 8'hF6, 8'hF8, 8'hFC: ok = 1'b1;
      default:                    ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [7:0] idx_reset_val(input logic [7:0] idx);
    logic [7:0] v;
    case (idx)
      8'hE0:   v = 8'h3C;
      8'hE2:   v = 8'h03;
      8'hE3:   v = 8'hFC;
      8'hE6:   v = 8'hDE;
      SER_A_IDX: v = SER_A_HOME;
      SER_B_IDX: v = SER_B_HOME;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/idx_cfg_decode.sv
module idx_cfg_decode #(
  parameter int unsigned          ADDR_W  = 16,
  parameter logic [ADDR_W-1:0]    IO_BASE = 'h3F0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dec_en,
  output logic              hit_idx,
  output logic              hit_dat
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = IO_BASE + ADDR_W'(1);

  assign hit_idx = dec_en && (addr == IO_BASE);
  assign hit_dat = dec_en && (addr == DAT_ADDR);
endmodule

// File: rtl/idx_cfg_guard.sv
module idx_cfg_guard
  import idx_cfg_pkg::*;
(
  input  logic       dat_wr,
  input  logic [7:0] index,
  input  logic [7:0] wbyte,
  output logic       commit,
  output logic [1:0] reloc_hit
);
  assign commit       = dat_wr && idx_writable(index);
  assign reloc_hit[0] = commit && (index == SER_A_IDX) && (wbyte != SER_A_HOME);
  assign reloc_hit[1] = commit && (index == SER_B_IDX) && (wbyte != SER_B_HOME);
endmodule

// File: rtl/idx_cfg_regs.sv
module idx_cfg_regs
  import idx_cfg_pkg::*;
#(
  parameter int unsigned WIN_BASE  = 224,
  parameter int unsigned WIN_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wbyte,
  output logic [7:0] rbyte
);
  localparam int unsigned OFF_W = (WIN_DEPTH > 1) ? $clog2(WIN_DEPTH) : 1;
  localparam logic [7:0]  BASE8 = 8'(WIN_BASE);

  logic [7:0] slots [WIN_DEPTH];
  logic [7:0] off;
  logic       in_win;

  assign off    = idx - BASE8;
  assign in_win = (idx >= BASE8) && ({1'b0, off} < 9'(WIN_DEPTH));

  // storage only where the index is writable; protected slots are constant zero
  for (genvar g = 0; g < int'(WIN_DEPTH); g++) begin : g_slot
    localparam logic [7:0] SLOT_IDX = 8'(WIN_BASE + g);
    if (idx_writable(SLOT_IDX)) begin : g_live
      logic [7:0] val_q;
      always_ff @(posedge clk) begin
        if (rst)
          val_q <= idx_reset_val(SLOT_IDX);
        else if (we && idx == SLOT_IDX)
          val_q <= wbyte;
      end
      assign slots[g] = val_q;
    end else begin : g_fixed
      assign slots[g] = 8'h00;
    end
  end

  assign rbyte = in_win ? slots[off[OFF_W-1:0]] : 8'h00;
endmodule

// File: rtl/idx_cfg_port.sv
module idx_cfg_port
  import idx_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IO_BASE   = 'h3F0,
  parameter int unsigned       WIN_BASE  = 224,
  parameter int unsigned       WIN_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  input  logic              io_dec_en,
  output logic [7:0]        io_rdata,
  output logic              io_ack,
  output logic [1:0]        reloc_flag
);
  logic       hit_idx, hit_dat;
  logic       commit;
  logic [1:0] reloc_hit;
  logic [7:0] index_q;
  logic [7:0] sel_byte;
  logic [7:0] rdata_q;
  logic       ack_q;
  logic [1:0] reloc_q;

  idx_cfg_decode #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_decode (
    .addr    (io_addr),
    .dec_en  (io_dec_en),
    .hit_idx (hit_idx),
    .hit_dat (hit_dat)
  );

  idx_cfg_guard u_guard (
    .dat_wr    (hit_dat && io_wr),
    .index     (index_q),
    .wbyte     (io_wdata),
    .commit    (commit),
    .reloc_hit (reloc_hit)
  );

  idx_cfg_regs #(.WIN_BASE(WIN_BASE), .WIN_DEPTH(WIN_DEPTH)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (commit),
    .idx   (index_q),
    .wbyte (io_wdata),
    .rbyte (sel_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= 8'h00;
      rdata_q <= 8'hFF;
      ack_q   <= 1'b0;
      reloc_q <= 2'b00;
    end else begin
      if (hit_idx && io_wr)
        index_q <= io_wdata;
      rdata_q <= ((hit_idx || hit_dat) && io_rd) ? sel_byte : 8'hFF;
      ack_q   <= (hit_idx || hit_dat) && (io_rd || io_wr);
      reloc_q <= reloc_q | reloc_hit;
    end
  end

  assign io_rdata   = rdata_q;
  assign io_ack     = ack_q;
  assign reloc_flag = reloc_q;
endmodule

// File: rtl/idx_cfg_port_chk.sv
module idx_cfg_port_chk
  import idx_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] IO_BASE = 'h3F0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_wdata,
  input logic              io_dec_en,
  input logic [7:0]        io_rdata,
  input logic              io_ack,
  input logic [1:0]        reloc_flag,
  input logic [7:0]        index_q,
  input logic [7:0]        sel_byte
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = IO_BASE + ADDR_W'(1);

  logic on_pair;
  assign on_pair = (io_addr == IO_BASE) || (io_addr == DAT_ADDR);

  assert_index_load_R1: assert property (@(posedge clk) disable iff (rst)
    (io_dec_en && io_wr && io_addr == IO_BASE) |=> index_q == $past(io_wdata));

  assert_read_claim_R2: assert property (@(posedge clk) disable iff (rst)
    (io_dec_en && io_rd && on_pair) |=> io_ack);

  assert_store_value_R3: assert property (@(posedge clk) disable iff (rst)
    (io_dec_en && io_wr && io_addr == DAT_ADDR && idx_writable(index_q))
      |=> sel_byte == $past(io_wdata));

  assert_protected_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (io_dec_en && io_rd && on_pair && !idx_writable(index_q)) |=> io_rdata == 8'h00);

  assert_flag_a_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    reloc_flag[0] |=> reloc_flag[0]);

  assert_flag_b_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    reloc_flag[1] |=> reloc_flag[1]);

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (rst)
    !io_dec_en |=> (!io_ack && io_rdata == 8'hFF));

  assert_gate_index_R7: assert property (@(posedge clk) disable iff (rst)
    (!io_dec_en && io_wr) |=> $stable(index_q));
endmodule

bind idx_cfg_port idx_cfg_port_chk #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_addr    (io_addr),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .io_wdata   (io_wdata),
  .io_dec_en  (io_dec_en),
  .io_rdata   (io_rdata),
  .io_ack     (io_ack),
  .reloc_flag (reloc_flag),
  .index_q    (index_q),
  .sel_byte   (sel_byte)
);

// File: tb/idx_cfg_port_bench.sv
module idx_cfg_port_bench;
  localparam logic [15:0] A_IDX = 16'h03F0;
  localparam logic [15:0] A_DAT = 16'h03F1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        io_dec_en = 1'b1;
  logic [7:0]  io_rdata;
  logic        io_ack;
  logic [1:0]  reloc_flag;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] got_d;
  logic       got_a;

  always #2 clk = ~clk;

  idx_cfg_port u_idx_cfg_port (
    .clk (clk), .rst (rst), .io_addr (io_addr), .io_rd (io_rd), .io_wr (io_wr),
    .io_wdata (io_wdata), .io_dec_en (io_dec_en), .io_rdata (io_rdata),
    .io_ack (io_ack), .reloc_flag (reloc_flag)
  );

  // {index, write byte, expected read-back}
  localparam logic [23:0] VEC [13] = '{
    24'hE0_55_55, 24'hE1_A5_A5, 24'hE4_33_00, 24'hDF_11_00, 24'h00_FF_00,
    24'hEE_81_81, 24'hF2_7E_7E, 24'hF3_99_00, 24'hF4_C3_C3, 24'hF8_01_01,
    24'hFC_80_80, 24'hFD_44_00, 24'hE9_12_00
  };

  function automatic bit m_writable(input int i);
    if (i < 'hE0) return 1'b0;
    case (i)
      'hE4, 'hE5, 'hE9, 'hEA, 'hEB, 'hEC, 'hED, 'hF3, 'hF5, 'hF7,
      'hF9, 'hFA, 'hFB, 'hFD, 'hFE, 'hFF: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] m_reset(input int i);
    case (i)
      'hE0: return 8'h3C;  'hE2: return 8'h03;  'hE3: return 8'hFC;
      'hE6: return 8'hDE;  'hE7: return 8'hFE;  'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic rd, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = wd;
    @(posedge clk);
    #1;
    got_d = io_rdata; got_a = io_ack;
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R9 reset ack", {7'b0, io_ack}, 8'h00);
    chk("R9 reset rdata", io_rdata, 8'hFF);
    chk("R6 reset flags", {6'b0, reloc_flag}, 8'h00);
    bus(A_DAT, 1'b1, 1'b0, 8'h00);
    chk("R1 index reset selects 0x00", got_d, 8'h00);

    // R5: every reset value
    for (int i = 0; i < 256; i++) begin
      bus(A_IDX, 1'b0, 1'b1, 8'(i));
      bus(A_DAT, 1'b1, 1'b0, 8'h00);
      chk($sformatf("R5 reset idx %02h", i), got_d, m_reset(i));
    end

    // table of write/read-back vectors (R3, R4)
    for (int k = 0; k < 13; k++) begin
      bus(A_IDX, 1'b0, 1'b1, VEC[k][23:16]);
      bus(A_DAT, 1'b0, 1'b1, VEC[k][15:8]);
      chk("R9 write claim", {7'b0, got_a}, 8'h01);
      bus(A_DAT, 1'b1, 1'b0, 8'h00);
      chk($sformatf("R3/R4 vector idx %02h", VEC[k][23:16]), got_d, VEC[k][7:0]);
      chk("R2 read claim", {7'b0, got_a}, 8'h01);
    end
    chk("R6 no flag from other writes", {6'b0, reloc_flag}, 8'h00);

    // R1: index write leaves contents alone; read via index port too (R2)
    bus(A_IDX, 1'b0, 1'b1, 8'hE3);
    bus(A_IDX, 1'b1, 1'b0, 8'h00);
    chk("R2 read through index port", got_d, 8'hFC);
    bus(A_IDX, 1'b0, 1'b1, 8'hE6);
    bus(A_DAT, 1'b1, 1'b0, 8'h00);
    chk("R1 index write keeps E6", got_d, 8'hDE);
    bus(A_IDX, 1'b0, 1'b1, 8'hE0);
    bus(A_DAT, 1'b1, 1'b0, 8'h00);
    chk("R1 index write keeps E0", got_d, 8'h55);

    // R8: read and write in one cycle
    bus(A_IDX, 1'b0, 1'b1, 8'hE2);
    bus(A_DAT, 1'b1, 1'b1, 8'h77);
    chk("R8 same-cycle old value", got_d, 8'h03);
    bus(A_DAT, 1'b1, 1'b0, 8'h00);
    chk("R8 new value after", got_d, 8'h77);

    // R6: relocation flags
    bus(A_IDX, 1'b0, 1'b1, 8'hE7);
    bus(A_DAT, 1'b0, 1'b1, 8'hFE);
    chk("R6 home value no flag", {6'b0, reloc_flag}, 8'h00);
    bus(A_DAT, 1'b0, 1'b1, 8'h12);
    chk("R6 flag A set", {6'b0, reloc_flag}, 8'h01);
    bus(A_DAT, 1'b1, 1'b0, 8'h00);
    chk("R6 moved value stored", got_d, 8'h12);
    bus(A_DAT, 1'b0, 1'b1, 8'hFE);
    chk("R6 flag A sticky", {6'b0, reloc_flag}, 8'h01);
    bus(A_IDX, 1'b0, 1'b1, 8'hE8);
    bus(A_DAT, 1'b0, 1'b1, 8'hBE);
    chk("R6 home B no flag", {6'b0, reloc_flag}, 8'h01);
    bus(A_DAT, 1'b0, 1'b1, 8'h00);
    chk("R6 flag B set", {6'b0, reloc_flag}, 8'h03);

    // R3/R4: full sweep of write protection
    do_reset();
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      v = 8'(i) ^ 8'hA5;
      bus(A_IDX, 1'b0, 1'b1, 8'(i));
      bus(A_DAT, 1'b0, 1'b1, v);
      bus(A_DAT, 1'b1, 1'b0, 8'h00);
      chk($sformatf("R3/R4 sweep idx %02h", i), got_d, m_writable(i) ? v : 8'h00);
    end

    // R7: decode gate and foreign addresses
    do_reset();
    bus(A_IDX, 1'b0, 1'b1, 8'hE0);
    io_dec_en = 1'b0;
    bus(A_DAT, 1'b1, 1'b0, 8'h00);
    chk("R7 disabled rdata", got_d, 8'hFF);
    chk("R7 disabled ack", {7'b0, got_a}, 8'h00);
    bus(A_IDX, 1'b0, 1'b1, 8'hE2);
    chk("R7 disabled index write unclaimed", {7'b0, got_a}, 8'h00);
    bus(A_DAT, 1'b0, 1'b1, 8'h99);
    io_dec_en = 1'b1;
    bus(A_DAT, 1'b1, 1'b0, 8'h00);
    chk("R7 disabled writes dropped", got_d, 8'h3C);
    bus(16'h03F2, 1'b1, 1'b0, 8'h00);
    chk("R7 foreign read rdata", got_d, 8'hFF);
    chk("R7 foreign read ack", {7'b0, got_a}, 8'h00);
    bus(16'h13F1, 1'b0, 1'b1, 8'h44);
    bus(A_DAT, 1'b1, 1'b0, 8'h00);
    chk("R7 foreign write dropped", got_d, 8'h3C);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule